// File: doc/BRIEF.md
# Prioritised Nesting Interrupt Controller

This block gathers a parameterised set of external interrupt request lines and one non-maskable request. It decides, every cycle, whether a pending request should interrupt the code that is running now. When one should, it gives the processor side a one-cycle take pulse, the exception number and the handler address. The handler address is the vector base plus four times the exception number. Every external line has its own enable bit and its own programmable priority. Lower numbers mean more urgent requests. A global mask blocks all the configurable lines at once.

The controller records which handlers are active and keeps, in hardware, a stack of the priority levels they preempted. Because of this stack, nesting needs no software help. When the processor signals that a handler has finished, the most recent activation is removed and the previous running level comes back. If a pending request beats that restored level, it is taken on the next cycle, without first returning to the interrupted code. Configuration goes through a single write port with an operation code, a line index and a data word.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, take_o is 0, exc_num_o and vec_addr_o are 0, every line is disabled with priority 0, the global mask is clear, the vector base is 0, and nothing is pending or active.
- R2: A write with cfg_we_i high takes effect from the next cycle. The operation codes are: 0 sets the enable of line cfg_idx_i to cfg_wdata_i[0]; 1 sets its priority to cfg_wdata_i[PRIO_BITS-1:0]; 2 sets the global mask to cfg_wdata_i[0]; 3 sets the vector base to cfg_wdata_i with bits 1:0 forced to zero.
- R3: Requests are level-sensitive. A line that is high at a clock edge while that line is not active becomes pending at that edge. If the pending request wins, take_o is high for the cycle that follows the next edge.
- R4: A request is taken only when its level is strictly more urgent than the running level. When no handler is active, the running level is below every configurable priority. An equal or less urgent request stays pending and is not taken.
- R5: A more urgent request preempts a running handler. The level of the interrupted handler is saved, and up to 2**PRIO_BITS+1 activations can nest.
- R6: When enabled pending lines tie on priority, the line with the lowest number wins.
- R7: External line n has exception number 16+n, and the non-maskable request has exception number 2. vec_addr_o equals the vector base plus 4 times exc_num_o, so bits 1:0 are zero.
- R8: While the global mask is set, no configurable line is taken, and a disabled line is never taken. In both cases its pending bit is kept, so the request is taken once it is allowed.
- R9: A rising edge on nmi_i makes the non-maskable request pending. It is taken at the next decision, above every configurable level, whatever the enables and the mask. It is not re-entered while its own handler is active.
- R10: A ret_i pulse removes the most recent activation and restores the level that activation interrupted. No request is taken in a cycle in which ret_i is high. A ret_i pulse when nothing is active has no effect.
- R11: If, after a return, a pending request beats the restored level, it is taken at the very next edge (take_o is high one cycle after the ret_i cycle).
- R12: A line that is still high when its handler returns becomes pending again and is taken again.
- R13: A priority change affects later decisions only. An activation that is already stacked keeps the level it was taken at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | Level-sensitive external requests |
| nmi_i | input | 1 | Non-maskable request, edge detected |
| ret_i | input | 1 | Handler-finished strobe |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 2 | Configuration operation code |
| cfg_idx_i | input | IDX_W | Line selected by the write |
| cfg_wdata_i | input | ADDR_W | Write data |
| take_o | output | 1 | One-cycle pulse: an exception is taken |
| exc_num_o | output | 8 | Exception number of the taken request |
| vec_addr_o | output | ADDR_W | Vector table address of the taken request |

## Verification
The properties assume three things about the inputs. First, ret_i is pulsed only when the processor side has actually finished a handler that this block started. Second, nmi_i is held low between pulses, so that each edge stands for one request. Third, configuration writes never land in the same cycle as a decision the bench is observing. The stimulus follows these rules. It returns exactly once per take, leaves at least one low cycle between non-maskable pulses, and issues every write while the controller is idle or waiting with no change pending. Every take the bench expects is queued before the stimulus that should cause it, so any take that the queue does not anticipate is reported as a failure.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   typedef enum logic [1:0] {
      CFG_ENABLE = 2'd0,
      CFG_PRIO   = 2'd1,
      CFG_MASK   = 2'd2,
      CFG_VBASE  = 2'd3
   } cfg_op_e;

   localparam int unsigned EXC_W        = 8;
   localparam int unsigned MAX_EXT      = 240;
   localparam logic [7:0]  EXC_NMI      = 8'd2;
   localparam logic [7:0]  EXC_EXT_BASE = 8'd16;

endpackage

// File: rtl/irq_line.sv
module irq_line #(
   parameter int unsigned PRIO_BITS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic                 en_we_i,
   input  logic                 prio_we_i,
   input  logic                 en_val_i,
   input  logic [PRIO_BITS-1:0] prio_val_i,
   input  logic                 take_i,
   input  logic                 done_i,
   output logic                 pend_o,
   output logic                 en_o,
   output logic                 act_o,
   output logic [PRIO_BITS-1:0] prio_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
         en_o   <= 1'b0;
         act_o  <= 1'b0;
         prio_o <= '0;
      end else begin
         if (en_we_i)   en_o   <= en_val_i;
         if (prio_we_i) prio_o <= prio_val_i;
         // pending is latched from the level, never while this line's handler runs
         if (take_i)                 pend_o <= 1'b0;
         else if (req_i && !act_o)   pend_o <= 1'b1;
         if (take_i)      act_o <= 1'b1;
         else if (done_i) act_o <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned NUM_IRQ = 8,
   parameter int unsigned LVL_W   = 5,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [NUM_IRQ-1:0]            elig_i,
   input  logic [NUM_IRQ-1:0][LVL_W-1:0] lvl_i,
   output logic                          valid_o,
   output logic [IDX_W-1:0]              idx_o,
   output logic [LVL_W-1:0]              lvl_o
);

   logic             v_c [0:NUM_IRQ];
   logic [IDX_W-1:0] i_c [0:NUM_IRQ];
   logic [LVL_W-1:0] l_c [0:NUM_IRQ];

   assign v_c[0] = 1'b0;
   assign i_c[0] = '0;
   assign l_c[0] = '1;

   // ripple chain: a later line replaces the candidate only when strictly
   // more urgent, so ties settle on the lowest index
   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_stage
      logic better;
      assign better     = elig_i[g] && (!v_c[g] || (lvl_i[g] < l_c[g]));
      assign v_c[g+1]   = v_c[g] | elig_i[g];
      assign i_c[g+1]   = better ? IDX_W'(g) : i_c[g];
      assign l_c[g+1]   = better ? lvl_i[g]  : l_c[g];
   end

   assign valid_o = v_c[NUM_IRQ];
   assign idx_o   = i_c[NUM_IRQ];
   assign lvl_o   = l_c[NUM_IRQ];

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
   parameter int unsigned DEPTH    = 9,
   parameter int unsigned ID_W     = 4,
   parameter int unsigned LVL_W    = 5,
   parameter int unsigned SP_W     = 4,
   parameter int unsigned IDLE_LVL = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [ID_W-1:0]  push_id_i,
   input  logic [LVL_W-1:0] push_lvl_i,
   input  logic             pop_i,
   output logic [LVL_W-1:0] run_lvl_o,
   output logic [ID_W-1:0]  top_id_o,
   output logic [SP_W-1:0]  sp_o
);

   logic [SP_W-1:0]  sp_q;
   logic [ID_W-1:0]  id_w  [DEPTH];
   logic [LVL_W-1:0] lvl_w [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [ID_W-1:0]  id_q;
      logic [LVL_W-1:0] lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            id_q  <= '0;
            lvl_q <= '0;
         end else if (push_i && (sp_q == SP_W'(e))) begin
            id_q  <= push_id_i;
            lvl_q <= push_lvl_i;
         end
      end
      assign id_w[e]  = id_q;
      assign lvl_w[e] = lvl_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sp_q <= '0;
      else if (push_i)                     sp_q <= sp_q + SP_W'(1);
      else if (pop_i && (sp_q != '0))      sp_q <= sp_q - SP_W'(1);
   end

   always_comb begin
      top_id_o  = '0;
      run_lvl_o = LVL_W'(IDLE_LVL);
      for (int e = 0; e < DEPTH; e++) begin
         if (sp_q == SP_W'(e + 1)) begin
            top_id_o  = id_w[e];
            run_lvl_o = lvl_w[e];
         end
      end
   end

   assign sp_o = sp_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter  int unsigned NUM_IRQ   = 8,
   parameter  int unsigned PRIO_BITS = 3,
   parameter  int unsigned ADDR_W    = 32,
   localparam int unsigned IDX_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               nmi_i,
   input  logic               ret_i,
   input  logic               cfg_we_i,
   input  logic [1:0]         cfg_op_i,
   input  logic [IDX_W-1:0]   cfg_idx_i,
   input  logic [ADDR_W-1:0]  cfg_wdata_i,
   output logic               take_o,
   output logic [EXC_W-1:0]   exc_num_o,
   output logic [ADDR_W-1:0]  vec_addr_o
);

   localparam int unsigned LVL_W    = PRIO_BITS + 2;
   localparam int unsigned IDLE_LVL = (1 << PRIO_BITS) + 1;
   localparam int unsigned DEPTH    = (1 << PRIO_BITS) + 1;
   localparam int unsigned SP_W     = $clog2(DEPTH + 1);
   localparam int unsigned ID_W     = IDX_W + 1;

   if (NUM_IRQ < 1 || NUM_IRQ > MAX_EXT) begin : g_bad_count
      $error("NUM_IRQ out of range");
   end
   if (PRIO_BITS < 3 || PRIO_BITS > 8) begin : g_bad_prio
      $error("PRIO_BITS must give 8 to 256 levels");
   end
   if (ADDR_W < 12 || ADDR_W > 64) begin : g_bad_addr
      $error("ADDR_W must hold base plus 4 x 255");
   end

   cfg_op_e cfg_op;
   assign cfg_op = cfg_op_e'(cfg_op_i);

   // global configuration
   logic              gmask_q;
   logic [ADDR_W-1:0] vbase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gmask_q <= 1'b0;
         vbase_q <= '0;
      end else if (cfg_we_i) begin
         if (cfg_op == CFG_MASK)  gmask_q <= cfg_wdata_i[0];
         if (cfg_op == CFG_VBASE) vbase_q <= {cfg_wdata_i[ADDR_W-1:2], 2'b00};
      end
   end

   // per-line state
   logic [NUM_IRQ-1:0]                line_pend, line_en, line_act;
   logic [NUM_IRQ-1:0]                line_take, line_done;
   logic [NUM_IRQ-1:0][PRIO_BITS-1:0] line_prio;
   logic [NUM_IRQ-1:0][LVL_W-1:0]     line_lvl;
   logic [NUM_IRQ-1:0]                line_elig;

   logic             take_now, pop_now, win_nmi, win_valid;
   logic [LVL_W-1:0] win_lvl, run_lvl;
   logic [ID_W-1:0]  top_id, push_id;
   logic [SP_W-1:0]  nest_sp;
   logic             top_is_nmi;
   logic             arb_valid;
   logic [IDX_W-1:0] arb_idx;
   logic [LVL_W-1:0] arb_lvl;

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
      logic sel;
      assign sel = cfg_we_i && (cfg_idx_i == IDX_W'(n));

      irq_line #(.PRIO_BITS(PRIO_BITS)) u_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_i     (irq_i[n]),
         .en_we_i   (sel && (cfg_op == CFG_ENABLE)),
         .prio_we_i (sel && (cfg_op == CFG_PRIO)),
         .en_val_i  (cfg_wdata_i[0]),
         .prio_val_i(cfg_wdata_i[PRIO_BITS-1:0]),
         .take_i    (line_take[n]),
         .done_i    (line_done[n]),
         .pend_o    (line_pend[n]),
         .en_o      (line_en[n]),
         .act_o     (line_act[n]),
         .prio_o    (line_prio[n])
      );

      // level 0 is reserved for the non-maskable request
      assign line_lvl[n]  = LVL_W'(line_prio[n]) + LVL_W'(1);
      assign line_elig[n] = line_pend[n] && line_en[n] && !gmask_q;
      assign line_take[n] = take_now && !win_nmi && (arb_idx == IDX_W'(n));
      assign line_done[n] = pop_now && !top_is_nmi && (top_id[IDX_W-1:0] == IDX_W'(n));
   end

   irq_arbiter #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
      .elig_i (line_elig),
      .lvl_i  (line_lvl),
      .valid_o(arb_valid),
      .idx_o  (arb_idx),
      .lvl_o  (arb_lvl)
   );

   // non-maskable request: edge detected, bypasses enables and mask
   logic nmi_prev_q, nmi_pend_q, nmi_act_q;

   assign win_nmi   = nmi_pend_q;
   assign win_valid = nmi_pend_q || arb_valid;
   assign win_lvl   = nmi_pend_q ? '0 : arb_lvl;
   assign take_now  = win_valid && (win_lvl < run_lvl) && !ret_i;
   assign pop_now   = ret_i && (nest_sp != '0);
   assign top_is_nmi = top_id[ID_W-1];
   assign push_id   = win_nmi ? {1'b1, {IDX_W{1'b0}}} : {1'b0, arb_idx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev_q <= 1'b0;
         nmi_pend_q <= 1'b0;
         nmi_act_q  <= 1'b0;
      end else begin
         nmi_prev_q <= nmi_i;
         if (take_now && win_nmi)          nmi_pend_q <= 1'b0;
         else if (nmi_i && !nmi_prev_q)    nmi_pend_q <= 1'b1;
         if (take_now && win_nmi)          nmi_act_q  <= 1'b1;
         else if (pop_now && top_is_nmi)   nmi_act_q  <= 1'b0;
      end
   end

   irq_nest_stack #(
      .DEPTH   (DEPTH),
      .ID_W    (ID_W),
      .LVL_W   (LVL_W),
      .SP_W    (SP_W),
      .IDLE_LVL(IDLE_LVL)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (take_now),
      .push_id_i (push_id),
      .push_lvl_i(win_lvl),
      .pop_i     (pop_now),
      .run_lvl_o (run_lvl),
      .top_id_o  (top_id),
      .sp_o      (nest_sp)
   );

   // outputs to the processor side
   logic [EXC_W-1:0] win_exc;
   assign win_exc = win_nmi ? EXC_NMI : (EXC_EXT_BASE + EXC_W'(arb_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o     <= 1'b0;
         exc_num_o  <= '0;
         vec_addr_o <= '0;
      end else begin
         take_o <= take_now;
         if (take_now) begin
            exc_num_o  <= win_exc;
            vec_addr_o <= vbase_q + (ADDR_W'(win_exc) << 2);
         end
      end
   end

endmodule

module irq_prio_chk #(
   parameter int unsigned NUM_IRQ = 8,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned SP_W    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               take_o,
   input logic [7:0]         exc_num_o,
   input logic [ADDR_W-1:0]  vec_addr_o,
   input logic               ret_i,
   input logic               gmask_q,
   input logic               nmi_pend_q,
   input logic               nmi_act_q,
   input logic [NUM_IRQ-1:0] act,
   input logic [SP_W-1:0]    sp
);

   // R7
   exc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> ((exc_num_o == 8'd2) ||
                  ((exc_num_o >= 8'd16) && (int'(exc_num_o) < 16 + int'(NUM_IRQ)))));

   // R7
   vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (vec_addr_o[1:0] == 2'b00));

   // R8
   mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && $past(gmask_q)) |-> (exc_num_o == 8'd2));

   // R9
   nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(nmi_pend_q && !nmi_act_q && !ret_i) |-> (take_o && (exc_num_o == 8'd2)));

   // R10
   ret_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ret_i) |-> !take_o);

   // R5
   nest_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(act) + int'(nmi_act_q)) == int'(sp));

endmodule

bind irq_prio_ctrl irq_prio_chk #(
   .NUM_IRQ(NUM_IRQ),
   .ADDR_W (ADDR_W),
   .SP_W   (SP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .take_o    (take_o),
   .exc_num_o (exc_num_o),
   .vec_addr_o(vec_addr_o),
   .ret_i     (ret_i),
   .gmask_q   (gmask_q),
   .nmi_pend_q(nmi_pend_q),
   .nmi_act_q (nmi_act_q),
   .act       (line_act),
   .sp        (nest_sp)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_i = '0;
   logic        nmi_i = 1'b0;
   logic        ret_i = 1'b0;
   logic        cfg_we_i = 1'b0;
   logic [1:0]  cfg_op_i = '0;
   logic [2:0]  cfg_idx_i = '0;
   logic [31:0] cfg_wdata_i = '0;
   logic        take_o;
   logic [7:0]  exc_num_o;
   logic [31:0] vec_addr_o;

   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [31:0] vbase_m = '0;
   int          exp_exc [$];
   string       exp_tag [$];

   always #10 clk = ~clk;

   irq_prio_ctrl #(.NUM_IRQ(8), .PRIO_BITS(3), .ADDR_W(32)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_i      (irq_i),
      .nmi_i      (nmi_i),
      .ret_i      (ret_i),
      .cfg_we_i   (cfg_we_i),
      .cfg_op_i   (cfg_op_i),
      .cfg_idx_i  (cfg_idx_i),
      .cfg_wdata_i(cfg_wdata_i),
      .take_o     (take_o),
      .exc_num_o  (exc_num_o),
      .vec_addr_o (vec_addr_o)
   );

   task automatic check(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(logic [1:0] op, int idx, logic [31:0] d);
      cfg_we_i = 1'b1; cfg_op_i = op; cfg_idx_i = 3'(idx); cfg_wdata_i = d;
      @(negedge clk);
      cfg_we_i = 1'b0;
      if (op == 2'd3) vbase_m = d & ~32'h3;
   endtask

   task automatic expect_take(int exc, string tag);
      exp_exc.push_back(exc);
      exp_tag.push_back(tag);
   endtask

   task automatic drain(int n, string tag);
      tick(n);
      check(exp_exc.size() == 0, tag, exp_exc.size(), 0);
   endtask

   task automatic ret_pulse();
      ret_i = 1'b1;
      @(negedge clk);
      ret_i = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && take_o) begin
         if (exp_exc.size() == 0) begin
            check(1'b0, "R4 unexpected take", exc_num_o, 0);
         end else begin
            int    e;
            string t;
            e = exp_exc.pop_front();
            t = exp_tag.pop_front();
            check(exc_num_o == 8'(e), {t, " exc"}, exc_num_o, e);
            check(vec_addr_o == vbase_m + 32'(4 * e), {t, " R7 vec"},
                  vec_addr_o, vbase_m + 32'(4 * e));
         end
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1
      check(take_o == 1'b0, "R1 take", take_o, 0);
      check(exc_num_o == 8'd0, "R1 exc", exc_num_o, 0);
      check(vec_addr_o == 32'd0, "R1 vec", vec_addr_o, 0);

      // R2 configuration
      cfg(2'd3, 0, 32'h0000_1000);
      for (int i = 0; i < 8; i++) cfg(2'd0, i, 32'd1);
      cfg(2'd1, 0, 5); cfg(2'd1, 1, 3); cfg(2'd1, 2, 3); cfg(2'd1, 3, 1);
      cfg(2'd1, 4, 6); cfg(2'd1, 5, 2); cfg(2'd1, 6, 4); cfg(2'd1, 7, 7);

      // R3 timing from request to take
      irq_i[0] = 1'b1;
      expect_take(16, "R3");
      @(negedge clk);
      check(take_o == 1'b0, "R3 early", take_o, 0);
      @(negedge clk);
      check(take_o == 1'b1, "R3 take", take_o, 1);
      irq_i[0] = 1'b0;
      drain(3, "R3");

      // R4 less urgent waits, R5 more urgent preempts
      irq_i[4] = 1'b1;
      drain(4, "R4 lower");
      irq_i[4] = 1'b0;
      irq_i[1] = 1'b1;
      expect_take(17, "R5");
      drain(4, "R5");
      irq_i[1] = 1'b0;
      irq_i[2] = 1'b1;
      drain(4, "R4 equal");
      irq_i[2] = 1'b0;

      // R11 tail chain one cycle after return
      expect_take(18, "R11");
      ret_pulse();
      @(negedge clk);
      check(take_o == 1'b1, "R11 next edge", take_o, 1);
      drain(3, "R11");
      ret_pulse();
      drain(4, "R10 restored level");
      expect_take(20, "R10");
      ret_pulse();
      drain(4, "R10 idle");
      ret_pulse();
      drain(4, "R10 empty");
      ret_pulse();
      drain(4, "R10 underflow");

      // R6 tie goes to the lower line
      irq_i[1] = 1'b1; irq_i[2] = 1'b1;
      expect_take(17, "R6");
      drain(4, "R6");
      irq_i[1] = 1'b0; irq_i[2] = 1'b0;
      expect_take(18, "R6 second");
      ret_pulse();
      drain(4, "R6 second");
      ret_pulse();
      drain(4, "R6 idle");

      // R8 global mask, R9 non-maskable through it
      cfg(2'd2, 0, 32'd1);
      irq_i[3] = 1'b1;
      drain(5, "R8 mask");
      expect_take(2, "R9");
      nmi_i = 1'b1; @(negedge clk); nmi_i = 1'b0;
      drain(4, "R9");
      ret_pulse();
      drain(4, "R8 still masked");
      expect_take(19, "R8 unmask");
      cfg(2'd2, 0, 32'd0);
      drain(4, "R8 unmask");
      irq_i[3] = 1'b0;
      expect_take(2, "R9 preempt");
      nmi_i = 1'b1; @(negedge clk); nmi_i = 1'b0;
      drain(4, "R9 preempt");
      nmi_i = 1'b1; @(negedge clk); nmi_i = 1'b0;
      drain(4, "R9 no reentry");
      expect_take(2, "R9 after return");
      ret_pulse();
      drain(4, "R9 after return");
      ret_pulse();
      drain(4, "R9 back");
      ret_pulse();
      drain(4, "R9 idle");

      // R12 level still high after return
      irq_i[0] = 1'b1;
      expect_take(16, "R12");
      drain(4, "R12");
      expect_take(16, "R12 repend");
      ret_pulse();
      drain(5, "R12 repend");
      irq_i[0] = 1'b0;
      ret_pulse();
      drain(4, "R12 quiet");

      // R8 disabled line keeps its request
      cfg(2'd0, 5, 32'd0);
      irq_i[5] = 1'b1;
      drain(4, "R8 disabled");
      irq_i[5] = 1'b0;
      expect_take(21, "R8 enable");
      cfg(2'd0, 5, 32'd1);
      drain(4, "R8 enable");

      // R13 priority changes at run time
      irq_i[6] = 1'b1;
      drain(4, "R13 before");
      cfg(2'd1, 5, 7);
      drain(4, "R13 stacked level");
      expect_take(22, "R13");
      cfg(2'd1, 6, 1);
      drain(4, "R13");
      irq_i[6] = 1'b0;
      ret_pulse();
      drain(4, "R13 pop");
      ret_pulse();
      drain(4, "R13 idle");

      // R2 new vector base, low bits dropped
      cfg(2'd3, 0, 32'h0000_2003);
      irq_i[7] = 1'b1;
      expect_take(23, "R2");
      drain(4, "R2");
      irq_i[7] = 1'b0;
      ret_pulse();
      drain(4, "R2 idle");

      done = 1'b1;
      finish_run();
   end

endmodule